// File: doc/BRIEF.md
# DRAM Access Cycle Sequencer

This block turns one CPU bus request aimed at a DRAM-mapped region into the strobe sequence a DRAM device needs. A request carries an address, a read/write flag, two byte-lane enables, a region number and the per-region wait enables. The sequencer then steps through a precharge state, a row-address state and two column-address states. It drives the row half of the address and then the column half on the same pins, and it lowers the row strobe of the addressed region. The column strobes fall for the requested byte lanes in the last column state. A read returns its data together with a one-clock done pulse.

Slow devices can stretch an access by holding the wait input. The stretch can only happen between the two column states, and only when the addressed region's wait-enable bit is set. A select bit routes the upper/lower column strobes to one of two output pairs, and the other pair stays idle. While no access is running, a refresh request runs a column-before-row refresh with the refresh output held low. The timing of the refresh interval belongs to another block.

Top module: `dram_seq`

## Requirements
- R1: An accepted access runs the states precharge, row, first column and second column in that order, one clock each when no wait is inserted. `done` is high for exactly the one clock after the second column state, so it appears on the 4th rising edge after the accepting edge.
- R2: When bit `waitEnMask[reqRegion]` is 1, `waitIn` is sampled at the end of the first column state and at the end of every wait state. Each sample that is high adds one wait state, in which all column strobes stay high and the row strobe stays low.
- R3: When bit `waitEnMask[reqRegion]` is 0, `waitIn` has no effect and the access lasts exactly four states.
- R4: Region n (0..3) owns `rasN[n]`. In an access only that bit is low, from the row state through the second column state. All row strobes are high in precharge and idle.
- R5: `memAddr` carries `reqAddr[15:8]` (row) in the precharge and row states and `reqAddr[7:0]` (column) in the column and wait states.
- R6: Column strobes are low only in the second column state. `reqLanes[1]` selects the upper strobe and `reqLanes[0]` the lower strobe. `colSel`=0 uses pair `ucasAN`/`lcasAN` and `colSel`=1 uses pair `ucasBN`/`lcasBN`. The unused pair stays high.
- R7: For a write, `weN` is low and `memDoe` high with `memDout` = write data from the first column state through the second column state. For a read, `weN` stays high throughout.
- R8: Read data on `memDin` is latched at the end of the second column state and shown on `rdData` with `done`. It holds until the next read, and writes and refreshes leave it unchanged.
- R9: A `refReq` seen in idle without `reqValid` runs a refresh. In the first state all strobes are high. In the second state both column strobes of the `colSel` pair are low. In the third state those column strobes stay low and all four row strobes are low too. `rfshN` is low for all three states, `weN` stays high, and no `done` is produced.
- R10: After reset all strobes, `weN` and `rfshN` are high, `done` and `memDoe` are low, and `rdData` is 0.
- R11: `reqValid`, `refReq` and the request fields are sampled only in idle. Pulses that arrive during a running access are ignored, and so are changes to the request fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Access request pulse, sampled in idle |
| reqAddr | input | 16 | Access address, row in upper bits |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLanes | input | 2 | Byte-lane enables: bit 1 upper, bit 0 lower |
| reqRegion | input | 2 | Addressed DRAM region 0..3 |
| waitEnMask | input | 4 | Per-region wait enable |
| colSel | input | 1 | Column strobe pair select |
| wrData | input | 16 | Write data |
| refReq | input | 1 | Refresh request pulse, sampled in idle |
| waitIn | input | 1 | Wait request from the device side |
| memDin | input | 16 | Data returned by the DRAM |
| memAddr | output | 8 | Multiplexed row/column address |
| rasN | output | 4 | Per-region row strobes, active low |
| ucasAN | output | 1 | Upper column strobe, pair A |
| lcasAN | output | 1 | Lower column strobe, pair A |
| ucasBN | output | 1 | Upper column strobe, pair B |
| lcasBN | output | 1 | Lower column strobe, pair B |
| weN | output | 1 | Write enable, active low |
| rfshN | output | 1 | Refresh indicator, active low |
| memDout | output | 16 | Write data to the DRAM |
| memDoe | output | 1 | Data output enable |
| rdData | output | 16 | Latched read data |
| done | output | 1 | One-clock access completion pulse |

## Verification
All pin decodes come from one state register. A wrong state therefore shows up at the ports in the same clock it is entered: a row strobe for the wrong region, a column strobe one state early, or `weN` falling on a read. A skipped or repeated state moves `done` off its expected edge and makes the expected column state show idle pins. A stuck or mis-gated wait path shows as extra states with high column strobes, or as a missing stretch. The bench compares every pin in every clock of each access and refresh against values it derives from the request, so any such error is seen within one clock.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROW,
    ST_COL1,
    ST_WAIT,
    ST_COL2,
    ST_RPRE,
    ST_RCAS,
    ST_RRAS
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;     // capture an access request
    logic capRef;     // capture a refresh request
    logic rowStrobe;  // addressed row strobe low
    logic colAddr;    // column half on the address pins
    logic colStrobe;  // lane column strobes low
    logic writePhase; // write enable / data drive window
    logic lastCol;    // final column state of an access
    logic refOn;      // refresh cycle in progress
    logic refCas;     // refresh column strobes low
    logic refRas;     // refresh row strobes low
  } seqCtl_t;

endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    refReq,
  input  logic    waitIn,
  input  logic    waitAllowed,
  output seqCtl_t ctl
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid)    nextState = ST_PRE;
        else if (refReq) nextState = ST_RPRE;
      end
      ST_PRE:  nextState = ST_ROW;
      ST_ROW:  nextState = ST_COL1;
      ST_COL1,
      ST_WAIT: nextState = (waitAllowed && waitIn) ? ST_WAIT : ST_COL2;
      ST_COL2: nextState = ST_IDLE;
      ST_RPRE: nextState = ST_RCAS;
      ST_RCAS: nextState = ST_RRAS;
      ST_RRAS: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  logic inColumn;
  assign inColumn = (state == ST_COL1) || (state == ST_WAIT) || (state == ST_COL2);

  always_comb begin
    ctl.capReq     = (state == ST_IDLE) && reqValid;
    ctl.capRef     = (state == ST_IDLE) && !reqValid && refReq;
    ctl.rowStrobe  = (state == ST_ROW) || inColumn;
    ctl.colAddr    = inColumn;
    ctl.colStrobe  = (state == ST_COL2);
    ctl.writePhase = inColumn;
    ctl.lastCol    = (state == ST_COL2);
    ctl.refOn      = (state == ST_RPRE) || (state == ST_RCAS) || (state == ST_RRAS);
    ctl.refCas     = (state == ST_RCAS) || (state == ST_RRAS);
    ctl.refRas     = (state == ST_RRAS);
  end

  // R1
  pre_to_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_PRE |=> state == ST_ROW);

  // R1
  row_to_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_ROW |=> state == ST_COL1);

  // R3
  no_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COL1 && !waitAllowed) |=> state == ST_COL2);

  // R9
  ref_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RCAS |=> state == ST_RRAS);

endmodule

// File: rtl/dram_seq_dpath.sv
module dram_seq_dpath
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int COL_W       = 8,
  parameter int DATA_W      = 16,
  parameter int NUM_REGIONS = 4,
  localparam int ROW_W      = ADDR_W - COL_W,
  localparam int MUX_W      = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int REG_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqCtl_t                ctl,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic                   reqWrite,
  input  logic [1:0]             reqLanes,
  input  logic [REG_W-1:0]       reqRegion,
  input  logic [NUM_REGIONS-1:0] waitEnMask,
  input  logic                   colSel,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [DATA_W-1:0]      memDin,
  output logic                   waitAllowed,
  output logic [MUX_W-1:0]       memAddr,
  output logic [NUM_REGIONS-1:0] rasN,
  output logic                   ucasAN,
  output logic                   lcasAN,
  output logic                   ucasBN,
  output logic                   lcasBN,
  output logic                   weN,
  output logic                   rfshN,
  output logic [DATA_W-1:0]      memDout,
  output logic                   memDoe,
  output logic [DATA_W-1:0]      rdData,
  output logic                   done
);

  logic [ADDR_W-1:0] capAddr;
  logic              capWrite;
  logic [1:0]        capLanes;
  logic [REG_W-1:0]  capRegion;
  logic              capSel;
  logic              capWaitEn;
  logic [DATA_W-1:0] capWrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr   <= '0;
      capWrite  <= 1'b0;
      capLanes  <= '0;
      capRegion <= '0;
      capWaitEn <= 1'b0;
      capWrData <= '0;
    end else if (ctl.capReq) begin
      capAddr   <= reqAddr;
      capWrite  <= reqWrite;
      capLanes  <= reqLanes;
      capRegion <= reqRegion;
      capWaitEn <= waitEnMask[reqRegion];
      capWrData <= wrData;
    end
  end

  // pair select is shared by accesses and refresh
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          capSel <= 1'b0;
    else if (ctl.capReq || ctl.capRef)  capSel <= colSel;
  end

  assign waitAllowed = capWaitEn;

  // multiplexed address
  logic [ROW_W-1:0] rowBits;
  logic [COL_W-1:0] colBits;
  assign rowBits = capAddr[ADDR_W-1:COL_W];
  assign colBits = capAddr[COL_W-1:0];
  assign memAddr = ctl.colAddr ? MUX_W'(colBits) : MUX_W'(rowBits);

  // per-region row strobes
  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_ras
    assign rasN[i] = !((ctl.rowStrobe && (capRegion == REG_W'(i))) || ctl.refRas);
  end

  // lane strobes routed to one of two pin pairs
  logic [1:0] laneOn;
  logic [1:0] pairUpN, pairLoN;
  assign laneOn = ctl.colStrobe ? capLanes : (ctl.refCas ? 2'b11 : 2'b00);

  for (genvar p = 0; p < 2; p++) begin : g_pair
    logic pairAct;
    assign pairAct    = (capSel == 1'(p));
    assign pairUpN[p] = !(pairAct && laneOn[1]);
    assign pairLoN[p] = !(pairAct && laneOn[0]);
  end

  assign ucasAN = pairUpN[0];
  assign lcasAN = pairLoN[0];
  assign ucasBN = pairUpN[1];
  assign lcasBN = pairLoN[1];

  assign weN     = !(ctl.writePhase && capWrite);
  assign memDoe  = ctl.writePhase && capWrite;
  assign memDout = capWrData;
  assign rfshN   = !ctl.refOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      done   <= 1'b0;
    end else begin
      done <= ctl.lastCol;
      if (ctl.lastCol && !capWrite) rdData <= memDin;
    end
  end

  // R4
  ras_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.refRas |-> $onehot0(~rasN));

  // R6
  cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.refCas && !(ucasAN && lcasAN && ucasBN && lcasBN)) |-> !(&rasN));

  // R6
  one_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    !((!ucasAN || !lcasAN) && (!ucasBN || !lcasBN)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  refresh_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rfshN |-> weN);

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int COL_W       = 8,
  parameter int DATA_W      = 16,
  parameter int NUM_REGIONS = 4,
  localparam int ROW_W      = ADDR_W - COL_W,
  localparam int MUX_W      = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int REG_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic                   reqWrite,
  input  logic [1:0]             reqLanes,
  input  logic [REG_W-1:0]       reqRegion,
  input  logic [NUM_REGIONS-1:0] waitEnMask,
  input  logic                   colSel,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   refReq,
  input  logic                   waitIn,
  input  logic [DATA_W-1:0]      memDin,
  output logic [MUX_W-1:0]       memAddr,
  output logic [NUM_REGIONS-1:0] rasN,
  output logic                   ucasAN,
  output logic                   lcasAN,
  output logic                   ucasBN,
  output logic                   lcasBN,
  output logic                   weN,
  output logic                   rfshN,
  output logic [DATA_W-1:0]      memDout,
  output logic                   memDoe,
  output logic [DATA_W-1:0]      rdData,
  output logic                   done
);

  seqCtl_t ctl;
  logic    waitAllowed;

  dram_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .refReq      (refReq),
    .waitIn      (waitIn),
    .waitAllowed (waitAllowed),
    .ctl         (ctl)
  );

  dram_seq_dpath #(
    .ADDR_W      (ADDR_W),
    .COL_W       (COL_W),
    .DATA_W      (DATA_W),
    .NUM_REGIONS (NUM_REGIONS)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqAddr     (reqAddr),
    .reqWrite    (reqWrite),
    .reqLanes    (reqLanes),
    .reqRegion   (reqRegion),
    .waitEnMask  (waitEnMask),
    .colSel      (colSel),
    .wrData      (wrData),
    .memDin      (memDin),
    .waitAllowed (waitAllowed),
    .memAddr     (memAddr),
    .rasN        (rasN),
    .ucasAN      (ucasAN),
    .lcasAN      (lcasAN),
    .ucasBN      (ucasBN),
    .lcasBN      (lcasBN),
    .weN         (weN),
    .rfshN       (rfshN),
    .memDout     (memDout),
    .memDoe      (memDoe),
    .rdData      (rdData),
    .done        (done)
  );

endmodule

// File: tb/sim_dram_seq.sv
module sim_dram_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqLanes = '0;
  logic [1:0]  reqRegion = '0;
  logic [3:0]  waitEnMask = '0;
  logic        colSel = 1'b0;
  logic [15:0] wrData = '0;
  logic        refReq = 1'b0;
  logic        waitIn = 1'b0;
  logic [15:0] memDin = '0;
  logic [7:0]  memAddr;
  logic [3:0]  rasN;
  logic        ucasAN, lcasAN, ucasBN, lcasBN, weN, rfshN, memDoe, done;
  logic [15:0] memDout, rdData;

  int total = 0;
  int bad = 0;
  logic [15:0] lastRead = '0;

  dram_seq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqLanes(reqLanes), .reqRegion(reqRegion),
    .waitEnMask(waitEnMask), .colSel(colSel), .wrData(wrData),
    .refReq(refReq), .waitIn(waitIn), .memDin(memDin), .memAddr(memAddr),
    .rasN(rasN), .ucasAN(ucasAN), .lcasAN(lcasAN), .ucasBN(ucasBN),
    .lcasBN(lcasBN), .weN(weN), .rfshN(rfshN), .memDout(memDout),
    .memDoe(memDoe), .rdData(rdData), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // pin vector: rasN, {ucasA,lcasA,ucasB,lcasB}, weN, rfshN, done
  task automatic checkPins(input string what, input logic [3:0] eRas, input logic [3:0] eCas,
                           input logic eWe, input logic eRf, input logic eDone);
    logic [10:0] act, exp;
    act = {rasN, ucasAN, lcasAN, ucasBN, lcasBN, weN, rfshN, done};
    exp = {eRas, eCas, eWe, eRf, eDone};
    check(act === exp, what, 32'(act), 32'(exp));
  endtask

  task automatic doAccess(input int region, input logic [1:0] lanes, input logic wr,
                          input logic sel, input logic maskOn, input int waits,
                          input logic [15:0] addr, input logic noise);
    logic [3:0]  rasOn;
    logic [3:0]  casOn;
    logic [15:0] rdPat;
    logic [15:0] wdat;
    int effWaits;
    rasOn    = ~(4'b0001 << region);
    casOn    = sel ? {2'b11, ~lanes} : {~lanes, 2'b11};
    rdPat    = addr ^ 16'hA5C3;
    wdat     = addr ^ 16'h3C3C;
    effWaits = maskOn ? waits : 0;
    reqAddr    = addr;
    reqWrite   = wr;
    reqLanes   = lanes;
    reqRegion  = 2'(region);
    colSel     = sel;
    wrData     = wdat;
    waitEnMask = maskOn ? (4'b0001 << region) : ~(4'b0001 << region);
    memDin     = ~rdPat;
    reqValid   = 1'b1;
    step();
    // precharge: fields changed after capture must not matter (R11)
    reqValid = 1'b0;
    reqWrite = ~wr; colSel = ~sel; reqRegion = 2'(region + 1); reqAddr = ~addr; wrData = ~wdat;
    checkPins("R1 R4 precharge", 4'hF, 4'hF, 1'b1, 1'b1, 1'b0);
    check(memAddr === addr[15:8], "R5 row addr in precharge", 32'(memAddr), 32'(addr[15:8]));
    if (noise) begin reqValid = 1'b1; refReq = 1'b1; end
    step();
    reqValid = 1'b0; refReq = 1'b0;
    checkPins("R4 row state", rasOn, 4'hF, 1'b1, 1'b1, 1'b0);
    check(memAddr === addr[15:8], "R5 row addr in row state", 32'(memAddr), 32'(addr[15:8]));
    step();
    checkPins("R7 first column", rasOn, 4'hF, ~wr, 1'b1, 1'b0);
    check(memAddr === addr[7:0], "R5 column addr", 32'(memAddr), 32'(addr[7:0]));
    check(memDoe === wr, "R7 data enable", 32'(memDoe), 32'(wr));
    if (wr) check(memDout === wdat, "R7 write data", 32'(memDout), 32'(wdat));
    waitIn = (waits > 0);
    for (int i = 0; i < effWaits; i++) begin
      step();
      checkPins("R2 wait state", rasOn, 4'hF, ~wr, 1'b1, 1'b0);
      waitIn = (i + 1 < waits);
    end
    step();
    waitIn = 1'b0;
    memDin = rdPat;
    checkPins(maskOn ? "R6 second column" : "R3 R6 second column", rasOn, casOn, ~wr, 1'b1, 1'b0);
    check(memAddr === addr[7:0], "R5 column addr last", 32'(memAddr), 32'(addr[7:0]));
    step();
    memDin = 16'h0000;
    checkPins("R1 done cycle", 4'hF, 4'hF, 1'b1, 1'b1, 1'b1);
    if (!wr) lastRead = rdPat;
    check(rdData === lastRead, "R8 read data", 32'(rdData), 32'(lastRead));
    step();
    checkPins(noise ? "R11 idle after noise" : "R1 idle after done", 4'hF, 4'hF, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic doRefresh(input logic sel);
    logic [3:0] casRef;
    casRef = sel ? 4'b1100 : 4'b0011;
    colSel = sel;
    refReq = 1'b1;
    step();
    refReq = 1'b0; colSel = ~sel;
    checkPins("R9 refresh precharge", 4'hF, 4'hF, 1'b1, 1'b0, 1'b0);
    step();
    checkPins("R9 refresh column first", 4'hF, casRef, 1'b1, 1'b0, 1'b0);
    step();
    checkPins("R9 refresh row", 4'h0, casRef, 1'b1, 1'b0, 1'b0);
    step();
    checkPins("R9 refresh end", 4'hF, 4'hF, 1'b1, 1'b1, 1'b0);
    check(rdData === lastRead, "R8 rdData kept over refresh", 32'(rdData), 32'(lastRead));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    k = 0;
    @(negedge clk);
    @(negedge clk);
    checkPins("R10 pins in reset", 4'hF, 4'hF, 1'b1, 1'b1, 1'b0);
    check(memDoe === 1'b0, "R10 doe in reset", 32'(memDoe), 32'd0);
    check(rdData === 16'h0, "R10 rdData in reset", 32'(rdData), 32'd0);
    rstN = 1'b1;
    step();
    checkPins("R10 idle after reset", 4'hF, 4'hF, 1'b1, 1'b1, 1'b0);

    // sweep of region, lanes, direction and pair select
    for (int r = 0; r < 4; r++)
      for (int l = 0; l < 4; l++)
        for (int w = 0; w < 2; w++)
          for (int s = 0; s < 2; s++) begin
            doAccess(r, 2'(l), 1'(w), 1'(s), 1'(k & 1), 0, 16'h1234 + 16'(k * 16'h0357), 1'b0);
            k++;
          end

    // wait handling: enabled and disabled, 0..3 wait requests
    for (int r = 0; r < 4; r++)
      for (int m = 0; m < 2; m++)
        for (int n = 0; n < 4; n++) begin
          doAccess(r, 2'b11, 1'(n & 1), 1'(r & 1), 1'(m), n, 16'hBEEF ^ 16'(k * 16'h0A11), 1'b0);
          k++;
        end

    // requests during an access are dropped
    doAccess(1, 2'b10, 1'b0, 1'b0, 1'b0, 0, 16'h55AA, 1'b1);
    doAccess(3, 2'b01, 1'b1, 1'b1, 1'b1, 2, 16'hC0DE, 1'b1);

    // refresh on both pairs, then an access right after
    doRefresh(1'b0);
    doRefresh(1'b1);
    doAccess(2, 2'b11, 1'b0, 1'b1, 1'b1, 1, 16'h0F0F, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule